// File: doc/BRIEF.md
# Gated Indirect Configuration Window

This block sits behind a small I/O register window of four dword slots and turns it into an indirect path to configuration space. Host software writes a slot to set a master flag, another to set an enable flag, a third to load an address, and then uses the fourth slot as a data port. When the loaded address falls inside one of two configuration mirrors and both flags are on, data-slot traffic goes to a configuration-space port at an offset captured from the address. Everything else, including every flag and address write, is forwarded unchanged to the backing device that owns the window.

Host requests arrive on a valid/ready channel. The block takes one request at a time. `h_req_ready` is high only when nothing is in flight, and a request is taken on a cycle where both valid and ready are high. The block then issues exactly one downstream request on either the backing port or the configuration port. It holds that request's valid and payload until the target raises ready. For a read, it waits for the target's one-cycle response strobe and then presents `h_rsp_valid` with the data. That data stays stable until the host raises `h_rsp_ready`. Writes produce no host response. The slot index is the byte offset divided by four, so only whole-dword accesses exist.

Top module: `iowin_cfg_bridge`

## Requirements
- R1: After reset the master, enable and address-valid flags are clear and the captured offset is zero. The block is idle, with `h_req_ready` high and no downstream or response valid.
- R2: A write to slot 0 (offset 0x0) loads the master flag from data bit 0. A write to slot 1 (offset 0x4) loads the enable flag from data bit 0. All other data bits of these writes have no effect.
- R3: A write to slot 2 (offset 0x8) while master is set, with `data & ~0xFFF == 0x88000`, sets address-valid and captures `data[11:0]` as the offset.
- R4: A write to slot 2 while master is set, with `data & ~0xFF == 0x1800`, sets address-valid and captures `data[7:0]` zero-extended as the offset.
- R5: A write to slot 2 while master is set, with an address in neither mirror, clears address-valid.
- R6: A write to slot 2 while master is clear leaves address-valid and the captured offset unchanged.
- R7: An access to slot 3 (offset 0xC) is sent to the configuration port at the captured offset only when master, enable and address-valid are all set. Such a write is not forwarded to the backing port.
- R8: Every write that is not redirected, including flag and address writes, is forwarded to the backing port with the same slot and data.
- R9: A read that is not redirected returns the backing port's data unchanged. A redirected read returns the configuration port's data.
- R10: One transfer is in flight at a time. Each downstream request holds valid and payload until its ready is seen. A host response holds valid and data until `h_rsp_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_req_valid | input | 1 | Host request valid |
| h_req_ready | output | 1 | Host request ready (idle) |
| h_req_we | input | 1 | Host request is a write |
| h_req_slot | input | 2 | Dword slot, byte offset / 4 |
| h_req_wdata | input | DATA_W | Host write data |
| h_rsp_valid | output | 1 | Host read response valid |
| h_rsp_ready | input | 1 | Host accepts the response |
| h_rsp_rdata | output | DATA_W | Host read data |
| b_req_valid | output | 1 | Backing request valid |
| b_req_ready | input | 1 | Backing request ready |
| b_req_we | output | 1 | Backing request is a write |
| b_req_slot | output | 2 | Backing slot |
| b_req_wdata | output | DATA_W | Backing write data |
| b_rsp_valid | input | 1 | Backing read data strobe |
| b_rsp_rdata | input | DATA_W | Backing read data |
| c_req_valid | output | 1 | Config request valid |
| c_req_ready | input | 1 | Config request ready |
| c_req_we | output | 1 | Config request is a write |
| c_req_off | output | OFF_W | Config space offset |
| c_req_wdata | output | DATA_W | Config write data |
| c_rsp_valid | input | 1 | Config read data strobe |
| c_rsp_rdata | input | DATA_W | Config read data |

## Verification
Data-slot reads and writes are tried with every partial flag combination: no flags, master only, master and enable with no valid address, enable dropped, and master dropped after a valid address was loaded. This shows that redirection needs all three conditions. Address writes hit both mirrors, including their first and last offsets, and also values just outside each mirror and values with stray high bits. These cases separate the 12-bit and 8-bit capture masks from a mismatch. Flag writes with stray upper bits, and address writes made while master is clear, show which bits are ignored. Stalls on a backing ready and on the host response ready check that the payload holds.

// File: rtl/iowin_pkg.sv
package iowin_pkg;

  typedef enum logic [1:0] {
    SLOT_MASTER = 2'd0,
    SLOT_ENABLE = 2'd1,
    SLOT_ADDR   = 2'd2,
    SLOT_DATA   = 2'd3
  } slot_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } xfer_st_e;

  localparam int unsigned MIRROR_CNT = 2;

  // Mirror 0 is the wide (extended) window, mirror 1 the narrow one.
  function automatic logic [31:0] mirror_base(input int unsigned idx);
    return (idx == 0) ? 32'h0008_8000 : 32'h0000_1800;
  endfunction

  function automatic int unsigned mirror_bits(input int unsigned idx);
    return (idx == 0) ? 12 : 8;
  endfunction

endpackage

// File: rtl/iowin_mirror_match.sv
module iowin_mirror_match #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OFF_W  = 12,
  parameter logic [DATA_W-1:0] BASE = '0,
  parameter int unsigned BITS   = 8
) (
  input  logic [DATA_W-1:0] addr,
  output logic              hit,
  output logic [OFF_W-1:0]  off
);
  localparam logic [DATA_W-1:0] LOW_MASK = {DATA_W{1'b1}} >> (DATA_W - BITS);

  always_comb begin
    hit = ((addr & ~LOW_MASK) == BASE);
    off = addr[OFF_W-1:0] & LOW_MASK[OFF_W-1:0];
  end
endmodule

// File: rtl/iowin_flag_regs.sv
module iowin_flag_regs
  import iowin_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OFF_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  slot_e             slot,
  input  logic [DATA_W-1:0] wdata,
  output logic              master,
  output logic              enable,
  output logic              avalid,
  output logic [OFF_W-1:0]  off
);
  logic [MIRROR_CNT-1:0]            hit_v;
  logic [MIRROR_CNT-1:0][OFF_W-1:0] off_v;
  logic                             any_hit;
  logic [OFF_W-1:0]                 sel_off;

  for (genvar g = 0; g < MIRROR_CNT; g++) begin : g_mirror
    iowin_mirror_match #(
      .DATA_W (DATA_W),
      .OFF_W  (OFF_W),
      .BASE   (DATA_W'(mirror_base(g))),
      .BITS   (mirror_bits(g))
    ) u_match (
      .addr (wdata),
      .hit  (hit_v[g]),
      .off  (off_v[g])
    );
  end

  // Lowest-numbered mirror wins (ranges are disjoint by default).
  always_comb begin
    any_hit = 1'b0;
    sel_off = '0;
    for (int i = MIRROR_CNT - 1; i >= 0; i--) begin
      if (hit_v[i]) begin
        any_hit = 1'b1;
        sel_off = off_v[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      master <= 1'b0;
      enable <= 1'b0;
      avalid <= 1'b0;
      off    <= '0;
    end else if (upd) begin
      unique case (slot)
        SLOT_MASTER: master <= wdata[0];
        SLOT_ENABLE: enable <= wdata[0];
        SLOT_ADDR: begin
          if (master) begin
            avalid <= any_hit;
            if (any_hit) off <= sel_off;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/iowin_xfer_fsm.sv
module iowin_xfer_fsm
  import iowin_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OFF_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_req_valid,
  output logic              h_req_ready,
  input  logic              h_req_we,
  input  slot_e             h_req_slot,
  input  logic [DATA_W-1:0] h_req_wdata,
  output logic              h_rsp_valid,
  input  logic              h_rsp_ready,
  output logic [DATA_W-1:0] h_rsp_rdata,
  input  logic              route_cfg,
  input  logic [OFF_W-1:0]  cfg_off,
  output logic              accept,
  output logic              b_req_valid,
  input  logic              b_req_ready,
  output logic              b_req_we,
  output slot_e             b_req_slot,
  output logic [DATA_W-1:0] b_req_wdata,
  input  logic              b_rsp_valid,
  input  logic [DATA_W-1:0] b_rsp_rdata,
  output logic              c_req_valid,
  input  logic              c_req_ready,
  output logic              c_req_we,
  output logic [OFF_W-1:0]  c_req_off,
  output logic [DATA_W-1:0] c_req_wdata,
  input  logic              c_rsp_valid,
  input  logic [DATA_W-1:0] c_rsp_rdata
);
  xfer_st_e          st;
  logic              cmd_we;
  slot_e             cmd_slot;
  logic [DATA_W-1:0] cmd_wdata;
  logic              cmd_cfg;
  logic [OFF_W-1:0]  cmd_off;
  logic [DATA_W-1:0] rsp_q;
  logic              tgt_ready;
  logic              tgt_rsp;

  always_comb begin
    h_req_ready = (st == ST_IDLE);
    accept      = h_req_valid && h_req_ready;
    h_rsp_valid = (st == ST_RESP);
    h_rsp_rdata = rsp_q;
    b_req_valid = (st == ST_ISSUE) && !cmd_cfg;
    c_req_valid = (st == ST_ISSUE) && cmd_cfg;
    b_req_we    = cmd_we;
    b_req_slot  = cmd_slot;
    b_req_wdata = cmd_wdata;
    c_req_we    = cmd_we;
    c_req_off   = cmd_off;
    c_req_wdata = cmd_wdata;
    tgt_ready   = cmd_cfg ? c_req_ready : b_req_ready;
    tgt_rsp     = cmd_cfg ? c_rsp_valid : b_rsp_valid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cmd_we    <= 1'b0;
      cmd_slot  <= SLOT_MASTER;
      cmd_wdata <= '0;
      cmd_cfg   <= 1'b0;
      cmd_off   <= '0;
      rsp_q     <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (accept) begin
          cmd_we    <= h_req_we;
          cmd_slot  <= h_req_slot;
          cmd_wdata <= h_req_wdata;
          cmd_cfg   <= (h_req_slot == SLOT_DATA) && route_cfg;
          cmd_off   <= cfg_off;
          st        <= ST_ISSUE;
        end
        ST_ISSUE: if (tgt_ready) st <= cmd_we ? ST_IDLE : ST_WAIT;
        ST_WAIT: if (tgt_rsp) begin
          rsp_q <= cmd_cfg ? c_rsp_rdata : b_rsp_rdata;
          st    <= ST_RESP;
        end
        ST_RESP: if (h_rsp_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/iowin_cfg_bridge.sv
module iowin_cfg_bridge
  import iowin_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OFF_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_req_valid,
  output logic              h_req_ready,
  input  logic              h_req_we,
  input  logic [1:0]        h_req_slot,
  input  logic [DATA_W-1:0] h_req_wdata,
  output logic              h_rsp_valid,
  input  logic              h_rsp_ready,
  output logic [DATA_W-1:0] h_rsp_rdata,
  output logic              b_req_valid,
  input  logic              b_req_ready,
  output logic              b_req_we,
  output logic [1:0]        b_req_slot,
  output logic [DATA_W-1:0] b_req_wdata,
  input  logic              b_rsp_valid,
  input  logic [DATA_W-1:0] b_rsp_rdata,
  output logic              c_req_valid,
  input  logic              c_req_ready,
  output logic              c_req_we,
  output logic [OFF_W-1:0]  c_req_off,
  output logic [DATA_W-1:0] c_req_wdata,
  input  logic              c_rsp_valid,
  input  logic [DATA_W-1:0] c_rsp_rdata
);
  logic             accept;
  logic             flg_master;
  logic             flg_enable;
  logic             flg_avalid;
  logic [OFF_W-1:0] flg_off;
  logic             route_cfg;
  slot_e            in_slot;
  slot_e            out_slot;

  assign in_slot    = slot_e'(h_req_slot);
  assign b_req_slot = out_slot;
  assign route_cfg  = flg_master && flg_enable && flg_avalid;

  iowin_flag_regs #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd    (accept && h_req_we),
    .slot   (in_slot),
    .wdata  (h_req_wdata),
    .master (flg_master),
    .enable (flg_enable),
    .avalid (flg_avalid),
    .off    (flg_off)
  );

  iowin_xfer_fsm #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .h_req_valid (h_req_valid),
    .h_req_ready (h_req_ready),
    .h_req_we    (h_req_we),
    .h_req_slot  (in_slot),
    .h_req_wdata (h_req_wdata),
    .h_rsp_valid (h_rsp_valid),
    .h_rsp_ready (h_rsp_ready),
    .h_rsp_rdata (h_rsp_rdata),
    .route_cfg   (route_cfg),
    .cfg_off     (flg_off),
    .accept      (accept),
    .b_req_valid (b_req_valid),
    .b_req_ready (b_req_ready),
    .b_req_we    (b_req_we),
    .b_req_slot  (out_slot),
    .b_req_wdata (b_req_wdata),
    .b_rsp_valid (b_rsp_valid),
    .b_rsp_rdata (b_rsp_rdata),
    .c_req_valid (c_req_valid),
    .c_req_ready (c_req_ready),
    .c_req_we    (c_req_we),
    .c_req_off   (c_req_off),
    .c_req_wdata (c_req_wdata),
    .c_rsp_valid (c_rsp_valid),
    .c_rsp_rdata (c_rsp_rdata)
  );
endmodule

// File: rtl/iowin_cfg_bridge_chk.sv
module iowin_cfg_bridge_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OFF_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              h_req_valid,
  input logic              h_req_ready,
  input logic              h_req_we,
  input logic [1:0]        h_req_slot,
  input logic [DATA_W-1:0] h_req_wdata,
  input logic              h_rsp_valid,
  input logic              h_rsp_ready,
  input logic [DATA_W-1:0] h_rsp_rdata,
  input logic              b_req_valid,
  input logic              b_req_ready,
  input logic [1:0]        b_req_slot,
  input logic [DATA_W-1:0] b_req_wdata,
  input logic              c_req_valid,
  input logic              c_req_ready,
  input logic [OFF_W-1:0]  c_req_off,
  input logic [DATA_W-1:0] c_req_wdata,
  input logic              flg_master,
  input logic              flg_enable,
  input logic              flg_avalid,
  input logic [OFF_W-1:0]  flg_off
);
  logic take;
  assign take = h_req_valid && h_req_ready && h_req_we;

  p_single_flight_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({h_req_ready, b_req_valid, c_req_valid, h_rsp_valid}));

  p_cfg_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    c_req_valid |-> (flg_master && flg_enable && flg_avalid));

  p_cfg_offset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    c_req_valid |-> (c_req_off == flg_off));

  p_breq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (b_req_valid && !b_req_ready) |=> (b_req_valid && $stable(b_req_wdata) && $stable(b_req_slot)));

  p_creq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (c_req_valid && !c_req_ready) |=> (c_req_valid && $stable(c_req_wdata) && $stable(c_req_off)));

  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rsp_valid && !h_rsp_ready) |=> (h_rsp_valid && $stable(h_rsp_rdata)));

  p_addr_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && h_req_slot == 2'd2 && !flg_master) |=> ($stable(flg_avalid) && $stable(flg_off)));

  p_master_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && h_req_slot == 2'd0) |=> (flg_master == $past(h_req_wdata[0])));
endmodule

bind iowin_cfg_bridge iowin_cfg_bridge_chk #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .h_req_valid (h_req_valid),
  .h_req_ready (h_req_ready),
  .h_req_we    (h_req_we),
  .h_req_slot  (h_req_slot),
  .h_req_wdata (h_req_wdata),
  .h_rsp_valid (h_rsp_valid),
  .h_rsp_ready (h_rsp_ready),
  .h_rsp_rdata (h_rsp_rdata),
  .b_req_valid (b_req_valid),
  .b_req_ready (b_req_ready),
  .b_req_slot  (b_req_slot),
  .b_req_wdata (b_req_wdata),
  .c_req_valid (c_req_valid),
  .c_req_ready (c_req_ready),
  .c_req_off   (c_req_off),
  .c_req_wdata (c_req_wdata),
  .flg_master  (flg_master),
  .flg_enable  (flg_enable),
  .flg_avalid  (flg_avalid),
  .flg_off     (flg_off)
);

// File: tb/test_iowin_cfg_bridge.sv
module test_iowin_cfg_bridge;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_req_valid = 1'b0, h_req_we = 1'b0, h_rsp_ready = 1'b1;
  logic [1:0]  h_req_slot = 2'd0;
  logic [31:0] h_req_wdata = '0;
  logic        h_req_ready, h_rsp_valid;
  logic [31:0] h_rsp_rdata;
  logic        b_req_valid, b_req_we, b_req_ready = 1'b1, b_rsp_valid = 1'b0;
  logic [1:0]  b_req_slot;
  logic [31:0] b_req_wdata, b_rsp_rdata = '0;
  logic        c_req_valid, c_req_we, c_req_ready = 1'b1, c_rsp_valid = 1'b0;
  logic [11:0] c_req_off;
  logic [31:0] c_req_wdata, c_rsp_rdata = '0;

  always #(CLK_P/2) clk = ~clk;

  iowin_cfg_bridge i_iowin_cfg_bridge (
    .clk(clk), .rst_n(rst_n),
    .h_req_valid(h_req_valid), .h_req_ready(h_req_ready), .h_req_we(h_req_we),
    .h_req_slot(h_req_slot), .h_req_wdata(h_req_wdata),
    .h_rsp_valid(h_rsp_valid), .h_rsp_ready(h_rsp_ready), .h_rsp_rdata(h_rsp_rdata),
    .b_req_valid(b_req_valid), .b_req_ready(b_req_ready), .b_req_we(b_req_we),
    .b_req_slot(b_req_slot), .b_req_wdata(b_req_wdata),
    .b_rsp_valid(b_rsp_valid), .b_rsp_rdata(b_rsp_rdata),
    .c_req_valid(c_req_valid), .c_req_ready(c_req_ready), .c_req_we(c_req_we),
    .c_req_off(c_req_off), .c_req_wdata(c_req_wdata),
    .c_rsp_valid(c_rsp_valid), .c_rsp_rdata(c_rsp_rdata)
  );

  typedef struct {
    bit          cfg;
    bit          we;
    logic [1:0]  slot;
    logic [11:0] off;
    logic [31:0] data;
    string       tag;
  } item_t;

  item_t exp_q[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;

  // Reference state derived from the requirements.
  bit          m_master = 0, m_en = 0, m_av = 0;
  logic [11:0] m_off = '0;

  function automatic logic [31:0] back_data(input logic [1:0] s);
    return 32'hBAC0_0000 | 32'(s);
  endfunction
  function automatic logic [31:0] cfg_data(input logic [11:0] o);
    return 32'hC0F1_0000 | 32'(o);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic compare_item(input item_t got);
    item_t e;
    if (exp_q.size() == 0) begin
      check(1'b0, "R8 unexpected downstream transfer", {got.cfg, got.we, 18'h0, got.off}, 32'h0);
      return;
    end
    e = exp_q.pop_front();
    check(got.cfg == e.cfg, {e.tag, " port"}, 32'(got.cfg), 32'(e.cfg));
    check(got.we == e.we && got.slot == e.slot && got.off == e.off, {e.tag, " kind/slot/offset"},
          {got.we, 13'h0, 2'(got.slot), 4'h0, got.off}, {e.we, 13'h0, 2'(e.slot), 4'h0, e.off});
    check(got.data == e.data, {e.tag, " data"}, got.data, e.data);
  endtask

  // Monitor: handshakes seen at negedge complete at the following posedge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (b_req_valid && b_req_ready)
        compare_item('{cfg: 1'b0, we: b_req_we, slot: b_req_slot, off: 12'h0,
                       data: b_req_we ? b_req_wdata : 32'h0, tag: ""});
      if (c_req_valid && c_req_ready)
        compare_item('{cfg: 1'b1, we: c_req_we, slot: 2'd3, off: c_req_off,
                       data: c_req_we ? c_req_wdata : 32'h0, tag: ""});
    end
  end

  // Responders for the two downstream ports.
  initial begin
    bit b_pend = 0, c_pend = 0;
    logic [1:0]  b_s = '0;
    logic [11:0] c_o = '0;
    forever begin
      @(negedge clk);
      b_rsp_valid = b_pend;
      b_rsp_rdata = b_pend ? back_data(b_s) : 32'hDEAD_0000;
      c_rsp_valid = c_pend;
      c_rsp_rdata = c_pend ? cfg_data(c_o) : 32'hDEAD_0001;
      b_pend = 0;
      c_pend = 0;
      if (b_req_valid && b_req_ready && !b_req_we) begin b_pend = 1; b_s = b_req_slot; end
      if (c_req_valid && c_req_ready && !c_req_we) begin c_pend = 1; c_o = c_req_off; end
    end
  end

  // Driver: pushes the expected downstream item, then runs one host transfer.
  task automatic host_xfer(input bit we, input logic [1:0] slot, input logic [31:0] wd, input string tag);
    bit          redir;
    logic [31:0] exp_rd;
    item_t       e;
    redir  = (slot == 2'd3) && m_master && m_en && m_av;
    exp_rd = redir ? cfg_data(m_off) : back_data(slot);
    e = '{cfg: redir, we: we, slot: redir ? 2'd3 : slot, off: redir ? m_off : 12'h0,
          data: we ? wd : 32'h0, tag: tag};
    exp_q.push_back(e);
    if (we) begin
      case (slot)
        2'd0: m_master = wd[0];
        2'd1: m_en = wd[0];
        2'd2: if (m_master) begin
          if ((wd & ~32'hFFF) == 32'h0008_8000) begin m_av = 1; m_off = wd[11:0]; end
          else if ((wd & ~32'hFF) == 32'h0000_1800) begin m_av = 1; m_off = {4'h0, wd[7:0]}; end
          else m_av = 0;
        end
        default: ;
      endcase
    end
    @(negedge clk);
    h_req_valid = 1'b1; h_req_we = we; h_req_slot = slot; h_req_wdata = wd;
    while (!h_req_ready) @(negedge clk);
    @(negedge clk);
    h_req_valid = 1'b0;
    if (!we) begin
      while (!h_rsp_valid) @(negedge clk);
      check(h_rsp_rdata == exp_rd, {tag, " read data"}, h_rsp_rdata, exp_rd);
    end
  endtask

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R10 watchdog expired actual=hung expected=complete");
      finish_run();
    end
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle after reset
    check(h_req_ready == 1'b1, "R1 ready after reset", 32'(h_req_ready), 32'h1);
    check(!b_req_valid && !c_req_valid && !h_rsp_valid, "R1 no valid after reset",
          {29'h0, b_req_valid, c_req_valid, h_rsp_valid}, 32'h0);
    host_xfer(0, 2'd3, 0, "R1 data read after reset goes to backing");

    // R6 / R8: address write with master clear
    host_xfer(1, 2'd2, 32'h0008_8123, "R6 address write, master clear");
    host_xfer(1, 2'd0, 32'hFFFF_FFF1, "R2 master set, upper bits ignored");
    host_xfer(1, 2'd1, 32'h0000_0001, "R2 enable set");
    host_xfer(0, 2'd3, 0, "R6 no valid address yet, read to backing");
    host_xfer(1, 2'd3, 32'h1111_2222, "R8 data write without valid address");

    // R3: wide mirror
    host_xfer(1, 2'd2, 32'h0008_8ABC, "R3 wide mirror address");
    host_xfer(0, 2'd3, 0, "R7 redirected read wide");
    host_xfer(1, 2'd3, 32'h0000_1234, "R7 redirected write not forwarded");
    host_xfer(1, 2'd2, 32'h0008_8FFF, "R3 wide mirror top offset");
    host_xfer(0, 2'd3, 0, "R9 redirected read returns config data");

    // R4: narrow mirror
    host_xfer(1, 2'd2, 32'h0000_18F7, "R4 narrow mirror address");
    host_xfer(0, 2'd3, 0, "R4 redirected read narrow offset");
    host_xfer(1, 2'd2, 32'h0000_1800, "R4 narrow mirror base");
    host_xfer(1, 2'd3, 32'hA5A5_5A5A, "R7 redirected write narrow base");

    // R5: mismatches
    host_xfer(1, 2'd2, 32'h0000_19F7, "R5 just above narrow mirror");
    host_xfer(0, 2'd3, 0, "R5 cleared valid, read to backing");
    host_xfer(1, 2'd2, 32'h0008_8010, "R3 re-arm wide");
    host_xfer(1, 2'd2, 32'h1008_8010, "R5 stray high bits");
    host_xfer(0, 2'd3, 0, "R5 stray high bits read to backing");
    host_xfer(1, 2'd2, 32'h0008_7FFF, "R5 just below wide mirror");
    host_xfer(1, 2'd3, 32'h7777_0000, "R8 data write after mismatch");

    // R2: enable off via bit 0 only
    host_xfer(1, 2'd2, 32'h0008_8010, "R3 re-arm wide again");
    host_xfer(1, 2'd1, 32'hFFFF_FFFE, "R2 enable clear, upper bits ignored");
    host_xfer(0, 2'd3, 0, "R2 enable clear read to backing");
    host_xfer(1, 2'd3, 32'h0BAD_0BAD, "R8 data write with enable clear");
    host_xfer(1, 2'd1, 32'h1, "R2 enable set again");

    // R6: master drop keeps valid and offset
    host_xfer(1, 2'd0, 32'h2, "R2 master clear");
    host_xfer(0, 2'd3, 0, "R7 master clear read to backing");
    host_xfer(1, 2'd2, 32'h0000_1234, "R6 mismatch ignored while master clear");
    host_xfer(1, 2'd0, 32'h1, "R2 master set again");
    host_xfer(0, 2'd3, 0, "R6 offset kept through gated write");
    host_xfer(0, 2'd0, 0, "R9 flag slot read to backing");
    host_xfer(0, 2'd2, 0, "R9 address slot read to backing");

    // R10: backing request stall
    @(posedge clk); #1 b_req_ready = 1'b0;
    host_xfer(1, 2'd1, 32'h0000_0003, "R10 stalled backing write");
    held = b_req_wdata;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(b_req_valid && !h_req_ready, "R10 request held during stall",
            {30'h0, b_req_valid, h_req_ready}, 32'h2);
      check(b_req_wdata == held && held == 32'h3, "R10 payload stable", b_req_wdata, 32'h3);
    end
    @(posedge clk); #1 b_req_ready = 1'b1;

    // R10: host response stall
    @(posedge clk); #1 h_rsp_ready = 1'b0;
    host_xfer(0, 2'd3, 0, "R10 redirected read with response stall");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(h_rsp_valid && h_rsp_rdata == cfg_data(12'h010), "R10 response held",
            h_rsp_rdata, cfg_data(12'h010));
    end
    @(posedge clk); #1 h_rsp_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(!h_rsp_valid && h_req_ready, "R10 idle after response taken",
          {30'h0, h_rsp_valid, h_req_ready}, 32'h1);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R8 all expected transfers seen", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    finish_run();
  end
endmodule